// File: doc/BRIEF.md
# Direct-Mapped Cache Line Array

This block is the storage half of a direct-mapped cache. It holds 256 lines. Each line carries a 5-bit tag, a valid flag, a dirty flag and four 16-bit words. A controller outside the block drives an 8-bit line index and a 3-bit byte offset. Bits [2:1] of the offset pick the word and bit 0 must be zero. Two mode inputs, `comp` and `write`, then choose one of four operations. All reads are combinational and all state changes happen on the rising clock edge.

In compare mode the stored tag is checked against `tag_in`. A store that misses leaves the line untouched, and a store that hits marks the line dirty. In access mode no check is made and the array behaves as a plain RAM. An access store writes the word, the tag and the valid flag, and it leaves the line clean. The controller uses access mode to fill a line after a miss and to read a victim line out before write-back. When the enable input is low, every output is zero and the mode inputs have no effect.

Top module: `cla_top`

## Requirements
- R1: A synchronous reset clears the valid and dirty flags of every line. After reset, any enabled read shows valid=0 and dirty=0.
- R2: When enable=1 and offset bit 0 is 1, err is 1 and no part of the array is modified, even when write=1. When offset bit 0 is 0, err is 0.
- R3: When enable=0, hit, dirty, valid, err, tag_out and data_out are all 0, and a write request leaves the array unchanged.
- R4: Compare-read (comp=1, write=0): hit is 1 in the same cycle exactly when the stored tag of the indexed line equals tag_in. In the same cycle, valid, dirty, tag_out and data_out show the indexed line and word.
- R5: Compare-write (comp=1, write=1) with a tag match: hit=1 and the dirty output is 0 in that cycle. At the clock edge, data_in is written to the selected word and the line's dirty flag becomes 1.
- R6: Compare-write with a tag mismatch: hit=0, and valid and dirty report the line's flags. The line's tag, flags and words are not modified.
- R7: Access-read (comp=0, write=0): hit=0, and tag_out, data_out, valid and dirty show the indexed line and word in the same cycle.
- R8: Access-write (comp=0, write=1): at the clock edge, data_in goes to the selected word, tag_in to the line's tag and valid_in to its valid flag, and the dirty flag is cleared to 0.
- R9: Whenever enable=1 and write=1, tag_out and data_out are 0.
- R10: offset[2:1] picks word 0..3 within the line and index picks line 0..255. A write changes only the word it addresses; the other words of that line and all other lines keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Operation enable; when low all outputs are 0 |
| index | input | 8 | Line select |
| offset | input | 3 | Byte offset; [2:1] word select, [0] must be 0 |
| comp | input | 1 | 1 = compare mode, 0 = access mode |
| write | input | 1 | 1 = store at the clock edge |
| tag_in | input | 5 | Tag to compare or to store |
| data_in | input | 16 | Word to store |
| valid_in | input | 1 | Valid flag written by an access-write |
| hit | output | 1 | Tag match during a compare operation |
| dirty | output | 1 | Dirty flag of the indexed line |
| tag_out | output | 5 | Stored tag of the indexed line (0 on writes) |
| data_out | output | 16 | Selected word (0 on writes) |
| valid | output | 1 | Valid flag of the indexed line |
| err | output | 1 | Misaligned offset indication |

## Verification
The assertions assume that every line a compare touches has had its tag stored by an access-write since the last reset. The tag store has no reset, so a compare against an unwritten tag has no defined outcome. The stimulus follows this rule: it only compares against lines it has already filled. The reference model marks never-written tags and words as unknown, and the checks skip those fields. The assertions also assume that the inputs are stable around the clock edge. The bench drives all inputs on the falling edge.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Operation selected by {comp, write}
    typedef enum logic [1:0] {
        OP_ACC_RD = 2'b00,
        OP_ACC_WR = 2'b01,
        OP_CMP_RD = 2'b10,
        OP_CMP_WR = 2'b11
    } cla_op_e;

    // Decoded command for one cycle
    typedef struct packed {
        logic err;        // misaligned offset seen
        logic hit;        // compare with tag match
        logic word_we;    // store data word
        logic fill_we;    // store tag/valid, clear dirty
        logic dirty_set;  // mark line dirty
        logic mask_dirty; // force dirty output low
        logic show_rd;    // drive tag_out/data_out
    } cla_cmd_t;

endpackage

// File: rtl/cla_decode.sv
module cla_decode
    import cla_pkg::*;
(
    input  logic     enable,
    input  logic     comp,
    input  logic     write,
    input  logic     offset_lsb,
    input  logic     tag_match,
    output cla_cmd_t cmd
);

    cla_op_e op;
    logic    legal;

    always_comb begin
        op    = cla_op_e'({comp, write});
        legal = enable && !offset_lsb;
        cmd   = '0;
        cmd.err     = enable && offset_lsb;
        cmd.show_rd = enable && !write;
        unique case (op)
            OP_ACC_RD: ;
            OP_ACC_WR: begin
                cmd.word_we = legal;
                cmd.fill_we = legal;
            end
            OP_CMP_RD: begin
                cmd.hit = enable && tag_match;
            end
            OP_CMP_WR: begin
                cmd.hit        = enable && tag_match;
                cmd.mask_dirty = tag_match;
                cmd.word_we    = legal && tag_match;
                cmd.dirty_set  = legal && tag_match;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cla_meta.sv
module cla_meta #(
    parameter int LINES = 256,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_we,
    input  logic             dirty_set,
    input  logic [TAG_W-1:0] tag_wr,
    input  logic             valid_wr,
    output logic [TAG_W-1:0] tag_rd,
    output logic             valid_rd,
    output logic             dirty_rd
);

    typedef struct packed {
        logic [LINES-1:0] valid;
        logic [LINES-1:0] dirty;
    } flags_t;

    flags_t           flags_d, flags_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_comb begin
        flags_d = flags_q;
        if (fill_we) begin
            flags_d.valid[idx] = valid_wr;
            flags_d.dirty[idx] = 1'b0;
        end else if (dirty_set) begin
            flags_d.dirty[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    // Tags carry no reset; valid flags qualify them
    always_ff @(posedge clk) begin
        if (fill_we) tag_q[idx] <= tag_wr;
    end

    assign tag_rd   = tag_q[idx];
    assign valid_rd = flags_q.valid[idx];
    assign dirty_rd = flags_q.dirty[idx];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags_q.valid == '0 && flags_q.dirty == '0)); // R1

    AST_FILL_FLAGS: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> (flags_q.valid[$past(idx)] == $past(valid_wr)
                     && !flags_q.dirty[$past(idx)]
                     && tag_q[$past(idx)] == $past(tag_wr))); // R8

    AST_DIRTY_MARK: assert property (@(posedge clk) disable iff (rst)
        (dirty_set && !fill_we) |=> flags_q.dirty[$past(idx)]); // R5

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fill_we && !dirty_set) |=> $stable(flags_q)); // R6

endmodule

// File: rtl/cla_data.sv
module cla_data #(
    parameter int LINES  = 256,
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int DEPTH  = LINES * WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] wsel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [IDX_W+WSEL_W-1:0] addr;
    logic [DATA_W-1:0]       mem_q [DEPTH];

    assign addr  = {idx, wsel};
    assign rdata = mem_q[addr];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    AST_WORD_LANDS: assert property (@(posedge clk)
        we |=> mem_q[$past(addr)] == $past(wdata)); // R10

endmodule

// File: rtl/cla_top.sv
module cla_top
    import cla_pkg::*;
#(
    parameter int LINES  = 256,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int OFF_W  = WSEL_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [IDX_W-1:0]  index,
    input  logic [OFF_W-1:0]  offset,
    input  logic              comp,
    input  logic              write,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              valid_in,
    output logic              hit,
    output logic              dirty,
    output logic [TAG_W-1:0]  tag_out,
    output logic [DATA_W-1:0] data_out,
    output logic              valid,
    output logic              err
);

    cla_cmd_t          cmd;
    logic [TAG_W-1:0]  tag_rd;
    logic              valid_rd;
    logic              dirty_rd;
    logic [DATA_W-1:0] word_rd;
    logic              tag_match;

    assign tag_match = (tag_rd == tag_in);

    cla_decode u_decode (
        .enable     (enable),
        .comp       (comp),
        .write      (write),
        .offset_lsb (offset[0]),
        .tag_match  (tag_match),
        .cmd        (cmd)
    );

    cla_meta #(.LINES(LINES), .TAG_W(TAG_W)) u_meta (
        .clk       (clk),
        .rst       (rst),
        .idx       (index),
        .fill_we   (cmd.fill_we),
        .dirty_set (cmd.dirty_set),
        .tag_wr    (tag_in),
        .valid_wr  (valid_in),
        .tag_rd    (tag_rd),
        .valid_rd  (valid_rd),
        .dirty_rd  (dirty_rd)
    );

    cla_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .idx   (index),
        .wsel  (offset[OFF_W-1:1]),
        .we    (cmd.word_we),
        .wdata (data_in),
        .rdata (word_rd)
    );

    always_comb begin
        hit      = cmd.hit;
        err      = cmd.err;
        valid    = enable && valid_rd;
        dirty    = enable && dirty_rd && !cmd.mask_dirty;
        tag_out  = cmd.show_rd ? tag_rd  : '0;
        data_out = cmd.show_rd ? word_rd : '0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!hit && !dirty && !valid && !err
                     && tag_out == '0 && data_out == '0)); // R3

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        err |-> (!cmd.word_we && !cmd.fill_we && !cmd.dirty_set)); // R2

    AST_WRITE_BLANK: assert property (@(posedge clk) disable iff (rst)
        (enable && write) |-> (tag_out == '0 && data_out == '0)); // R9

    AST_ACC_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !comp |-> !hit); // R7

    AST_MISS_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        (enable && comp && write && !hit) |-> !cmd.word_we); // R6

endmodule

// File: tb/tb_cla_top.sv
module tb_cla_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [7:0]  index;
    logic [2:0]  offset;
    logic        comp;
    logic        write;
    logic [4:0]  tag_in;
    logic [15:0] data_in;
    logic        valid_in;
    logic        hit, dirty, valid, err;
    logic [4:0]  tag_out;
    logic [15:0] data_out;

    always #2.5 clk = ~clk;

    cla_top dut (
        .clk(clk), .rst(rst), .enable(enable), .index(index), .offset(offset),
        .comp(comp), .write(write), .tag_in(tag_in), .data_in(data_in),
        .valid_in(valid_in), .hit(hit), .dirty(dirty), .tag_out(tag_out),
        .data_out(data_out), .valid(valid), .err(err)
    );

    typedef struct {
        logic        hit, dirty, valid, err;
        logic [4:0]  tag;
        logic [15:0] data;
        bit          chk_hit, chk_dirty, chk_tag, chk_data;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 0;

    // reference model
    bit          m_valid [256];
    bit          m_dirty [256];
    logic [4:0]  m_tag   [256];
    bit          m_tknown[256];
    logic [15:0] m_data  [256][4];
    bit          m_dknown[256][4];

    task automatic check(bit ok, string what, string req, int act, int exp_v);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    task automatic op(bit en, bit cmp, bit wr, int idx, logic [2:0] off,
                      logic [4:0] tin, logic [15:0] din, bit vin, string req);
        exp_t e;
        int   w;
        bit   match;
        @(negedge clk);
        enable = en; comp = cmp; write = wr; index = idx[7:0]; offset = off;
        tag_in = tin; data_in = din; valid_in = vin;
        w     = int'(off[2:1]);
        match = m_tknown[idx] && (m_tag[idx] == tin);
        e.req = req;
        e.err = en && off[0];
        if (!en) begin
            e.hit = 0; e.dirty = 0; e.valid = 0; e.tag = '0; e.data = '0;
            e.chk_hit = 1; e.chk_dirty = 1; e.chk_tag = 1; e.chk_data = 1;
        end else begin
            e.hit       = cmp && match;
            e.chk_hit   = !cmp || m_tknown[idx];
            e.valid     = m_valid[idx];
            e.dirty     = m_dirty[idx] && !(cmp && wr && match);
            e.chk_dirty = !(cmp && wr) || m_tknown[idx];
            e.tag       = wr ? 5'd0 : m_tag[idx];
            e.chk_tag   = wr || m_tknown[idx];
            e.data      = wr ? 16'd0 : m_data[idx][w];
            e.chk_data  = wr || m_dknown[idx][w];
        end
        sb_q.push_back(e);
        if (en && !off[0] && wr) begin
            if (!cmp) begin
                m_tag[idx] = tin; m_tknown[idx] = 1;
                m_valid[idx] = vin; m_dirty[idx] = 0;
                m_data[idx][w] = din; m_dknown[idx][w] = 1;
            end else if (match) begin
                m_data[idx][w] = din; m_dknown[idx][w] = 1;
                m_dirty[idx] = 1;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; enable = 0; comp = 0; write = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        foreach (m_valid[i]) begin m_valid[i] = 0; m_dirty[i] = 0; end
    endtask

    // monitor: compares before the next rising edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check(err == e.err,     "err",   e.req, int'(err),   int'(e.err));
                check(valid == e.valid, "valid", e.req, int'(valid), int'(e.valid));
                if (e.chk_hit)   check(hit == e.hit,     "hit",   e.req, int'(hit),   int'(e.hit));
                if (e.chk_dirty) check(dirty == e.dirty, "dirty", e.req, int'(dirty), int'(e.dirty));
                if (e.chk_tag)   check(tag_out == e.tag, "tag_out", e.req, int'(tag_out), int'(e.tag));
                if (e.chk_data)  check(data_out == e.data, "data_out", e.req, int'(data_out), int'(e.data));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        foreach (m_tknown[i]) begin
            m_tknown[i] = 0;
            for (int k = 0; k < 4; k++) m_dknown[i][k] = 0;
        end
        rst = 1; enable = 0; comp = 0; write = 0; index = 0; offset = 0;
        tag_in = 0; data_in = 0; valid_in = 0;
        do_reset();

        // R1: lines read invalid and clean after reset
        op(1, 0, 0, 0,   3'b000, 0, 0, 0, "R1");
        op(1, 0, 0, 5,   3'b010, 0, 0, 0, "R1");
        op(1, 0, 0, 255, 3'b110, 0, 0, 0, "R1");

        // R8: fill line 5 (R9 checked on each write)
        for (int w = 0; w < 4; w++)
            op(1, 0, 1, 5, 3'(w * 2), 5'h0A, 16'h5000 + 16'(w), 1, "R8");
        // R7, R10: read back each word
        for (int w = 0; w < 4; w++)
            op(1, 0, 0, 5, 3'(w * 2), 0, 0, 0, "R7");

        // R4: compare-read hit and miss
        op(1, 1, 0, 5, 3'b100, 5'h0A, 0, 0, "R4");
        op(1, 1, 0, 5, 3'b100, 5'h0B, 0, 0, "R4");

        // R5: compare-write hit, then read back
        op(1, 1, 1, 5, 3'b010, 5'h0A, 16'hBEEF, 0, "R5");
        op(1, 0, 0, 5, 3'b010, 0, 0, 0, "R5");
        op(1, 0, 0, 5, 3'b100, 0, 0, 0, "R10");

        // R6: compare-write miss leaves state
        op(1, 1, 1, 5, 3'b000, 5'h03, 16'h1111, 0, "R6");
        op(1, 0, 0, 5, 3'b000, 0, 0, 0, "R6");

        // R2: misaligned access-write has no effect
        op(1, 0, 1, 5, 3'b011, 5'h1F, 16'h2222, 0, "R2");
        op(1, 0, 0, 5, 3'b010, 0, 0, 0, "R2");
        op(1, 1, 0, 5, 3'b001, 5'h0A, 0, 0, "R2");

        // R3: disabled write has no effect, outputs zero
        op(0, 0, 1, 5, 3'b010, 5'h1F, 16'h3333, 0, "R3");
        op(0, 1, 0, 5, 3'b010, 5'h0A, 0, 0, "R3");
        op(1, 0, 0, 5, 3'b010, 0, 0, 0, "R3");

        // R8: access-write clears dirty; boundary line with valid_in=0
        op(1, 0, 1, 5, 3'b000, 5'h0A, 16'h4444, 1, "R8");
        op(1, 0, 0, 5, 3'b010, 0, 0, 0, "R8");
        op(1, 0, 1, 255, 3'b110, 5'h1F, 16'hFFFF, 0, "R8");
        op(1, 0, 0, 255, 3'b110, 0, 0, 0, "R8");
        op(1, 0, 1, 0, 3'b000, 5'h01, 16'h0123, 1, "R8");
        op(1, 1, 0, 0, 3'b000, 5'h01, 0, 0, "R4");

        // R10: many lines, distinct patterns
        for (int i = 0; i < 64; i++)
            for (int w = 0; w < 4; w++)
                op(1, 0, 1, i * 4 + 1, 3'(w * 2), 5'(i * 7 + 3),
                   16'(i * 16'h0391 + w * 16'h1013), 1, "R10");
        for (int i = 0; i < 64; i++)
            for (int w = 0; w < 4; w++)
                op(1, 1, (w == 3), i * 4 + 1, 3'(w * 2), 5'(i * 7 + 3),
                   16'hA000 + 16'(i), 0, "R10");
        for (int i = 0; i < 64; i++)
            op(1, 0, 0, i * 4 + 1, 3'b110, 0, 0, 0, "R10");

        // R1: second reset clears flags of filled lines
        @(negedge clk); @(negedge clk);
        do_reset();
        op(1, 0, 0, 5, 3'b000, 0, 0, 0, "R1");
        op(1, 0, 0, 1, 3'b110, 0, 0, 0, "R1");

        @(negedge clk); @(negedge clk);
        finish_run();
    end

endmodule